// File: doc/BRIEF.md
# Level-Gated Key Slot Store

The block holds keys and secret data for a boot chain in which every stage runs at a temporal isolation level. Software reaches the store through a simple request port. A request names a slot index, a 32-bit word within that slot and a direction. The answer follows one clock later and carries read data and an error flag. Each slot is 256 bits wide and is accessed as eight words. Each slot belongs to the area of either isolation level 1 or level 2. Whether a request may touch a slot depends on the isolation level driven in at that moment.

The first eight slots hold hardware keys. Software may fill them but can never read them back. Their contents leave the block only on a private 256-bit key bus that an AES engine reads, and a select input picks the slot. The remaining twenty-four slots are ordinary data slots that can be read and written. A regression clear input wipes every slot at once, so a lifecycle regression leaves no secret behind.

Top module: `kss_store`

## Requirements
- R1: After reset every slot holds zero, `rsp_valid` is low, `rsp_err` is low and `key_out` is zero.
- R2: A request accepted on a clock edge (`req_valid` high) is answered with `rsp_valid` high for exactly the following cycle. A permitted read of a data slot returns the word last written at that index and word offset, with `rsp_err` low.
- R3: Slot areas are fixed. Slots 0-3 and 8-19 belong to level 1. Slots 4-7 and 20-31 belong to level 2. Level codes are 0 (system), 1, 2 and 3. Access is permitted when the level is 0 or equals the slot's area level. Level 3 is therefore never permitted.
- R4: A request that is not permitted by R3 sets `rsp_err`, returns zero read data and leaves the slot contents unchanged.
- R5: Slots 0-7 are hardware key slots. A permitted write to one of them stores the word with `rsp_err` low. Any read of one of them returns zero with `rsp_err` high, whatever the level.
- R6: `key_out` carries the full contents of hardware slot `key_sel`, with word w at bits 32w+31..32w, when the current level is permitted on that slot by R3. Otherwise `key_out` is zero. The output follows `key_sel`, the level and the storage without any register stage.
- R7: A cycle with `clr_all` high sets every slot to zero. A request presented in that cycle has no effect on storage and is answered with `rsp_err` high and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iso_level | input | 2 | Current temporal isolation level (0 to 3) |
| clr_all | input | 1 | Regression clear of all slots |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 5 | Slot index |
| req_word | input | 3 | Word offset inside the slot |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request denied or hardware slot read |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| key_sel | input | 3 | Hardware key slot chosen for the key bus |
| key_out | output | 256 | Private key bus to the AES engine |

## Verification
The assertions check on every cycle that each request is answered one cycle later. They also check that an error response never carries data, that hardware slot reads and level-3 requests always fail, that the key bus is dark at level 3, and that the key bus is zero after a clear. Only the bench sweeps can show the per-level area mapping. The sweeps also show that denied writes leave contents untouched, that every word lands at the right index and offset, and that the key bus places words at the right bit positions.

// File: rtl/kss_pkg.sv
// Shared types for the level-gated key slot store.
// Assumes a two-bit isolation level with code 0 reserved for the system.
package kss_pkg;

    typedef enum logic [1:0] {
        LVL_SYS  = 2'd0,
        LVL_ROOT = 2'd1,
        LVL_UPD  = 2'd2,
        LVL_APP  = 2'd3
    } iso_level_t;

endpackage

// File: rtl/kss_access_ctrl.sv
// Access decision for one slot index at one isolation level.
// Works out the owning area of the slot and whether the level may use it.
// A grant also requires that the request is not a read of a hardware slot.
// Assumes slots below HW_SLOTS are hardware key slots.
module kss_access_ctrl
    import kss_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int HW_SLOTS  = 8,
    parameter int HW_SPLIT  = 4,
    parameter int SW_SPLIT  = 20,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [1:0]       level,
    input  logic [IDX_W-1:0] index,
    input  logic             is_write,
    output logic             permitted,
    output logic             hw_slot,
    output logic             grant
);

    iso_level_t area;
    iso_level_t cur;
    int unsigned idx_u;

    // Map the index onto its owning area level.
    always_comb begin
        idx_u = 32'(index);
        if (idx_u < 32'(HW_SPLIT))      area = LVL_ROOT;
        else if (idx_u < 32'(HW_SLOTS)) area = LVL_UPD;
        else if (idx_u < 32'(SW_SPLIT)) area = LVL_ROOT;
        else                            area = LVL_UPD;
    end

    // Level check, hardware-slot detection and final grant.
    always_comb begin
        cur       = iso_level_t'(level);
        permitted = (cur == LVL_SYS) || (cur == area);
        hw_slot   = (32'(index) < 32'(HW_SLOTS));
        grant     = permitted && !(hw_slot && !is_write);
    end

endmodule

// File: rtl/kss_slot_array.sv
// Register storage for all slots, word addressable.
// One write port and one read port. A clear input zeroes every slot and
// takes priority over a write in the same cycle. The hardware slots are also
// brought out flat for the key bus.
module kss_slot_array #(
    parameter int NUM_SLOTS  = 32,
    parameter int HW_SLOTS   = 8,
    parameter int SLOT_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int WOFF_W    = $clog2(SLOT_WORDS),
    localparam int SLOT_W    = SLOT_WORDS * WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [WOFF_W-1:0]          wr_word,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [WOFF_W-1:0]          rd_word,
    output logic [WORD_W-1:0]          rd_data,
    output logic [HW_SLOTS*SLOT_W-1:0] hw_flat
);

    logic [WORD_W-1:0] mem [NUM_SLOTS][SLOT_WORDS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_word
            // One storage word: reset, clear, or addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    mem[s][w] <= '0;
                else if (we && (32'(wr_idx) == s) && (32'(wr_word) == w))
                    mem[s][w] <= wr_data;
            end
        end
    end

    for (genvar h = 0; h < HW_SLOTS; h++) begin : g_hw
        for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_hw_word
            // Flatten one hardware key word onto the key bus bundle.
            always_comb hw_flat[h*SLOT_W + w*WORD_W +: WORD_W] = mem[h][w];
        end
    end

    // Read port multiplexer.
    always_comb rd_data = mem[rd_idx][rd_word];

endmodule

// File: rtl/kss_key_port.sv
// Private key bus towards the AES engine.
// Selects one hardware slot and forces zero when the level is not
// permitted on it. Purely combinational.
module kss_key_port #(
    parameter int HW_SLOTS   = 8,
    parameter int SLOT_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int KSEL_W    = $clog2(HW_SLOTS),
    localparam int SLOT_W    = SLOT_WORDS * WORD_W
) (
    input  logic [HW_SLOTS*SLOT_W-1:0] hw_flat,
    input  logic [KSEL_W-1:0]          key_sel,
    input  logic                       key_ok,
    output logic [SLOT_W-1:0]          key_out
);

    // Pick the selected slot and gate it with the level decision.
    always_comb begin
        key_out = '0;
        if (key_ok)
            key_out = hw_flat[32'(key_sel)*SLOT_W +: SLOT_W];
    end

endmodule

// File: rtl/kss_store.sv
// Level-gated key slot store, top level.
// Takes one request per cycle and answers it one cycle later. Writes land
// in the same edge that accepts them. Assumes iso_level is stable around
// the accepting edge and that the key consumer samples key_out directly.
module kss_store #(
    parameter int NUM_SLOTS  = 32,
    parameter int HW_SLOTS   = 8,
    parameter int HW_SPLIT   = 4,
    parameter int SW_SPLIT   = 20,
    parameter int SLOT_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int WOFF_W    = $clog2(SLOT_WORDS),
    localparam int KSEL_W    = $clog2(HW_SLOTS),
    localparam int SLOT_W    = SLOT_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        iso_level,
    input  logic              clr_all,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [WOFF_W-1:0] req_word,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic [KSEL_W-1:0] key_sel,
    output logic [SLOT_W-1:0] key_out
);

    logic                       req_perm, req_hw, req_grant;
    logic                       key_perm, key_hw, key_grant;
    logic                       wr_en;
    logic [WORD_W-1:0]          rd_word_data;
    logic [HW_SLOTS*SLOT_W-1:0] hw_flat;
    logic [IDX_W-1:0]           key_idx;

    kss_access_ctrl #(
        .NUM_SLOTS(NUM_SLOTS), .HW_SLOTS(HW_SLOTS),
        .HW_SPLIT(HW_SPLIT),   .SW_SPLIT(SW_SPLIT)
    ) i_req_acc (
        .level(iso_level), .index(req_index), .is_write(req_write),
        .permitted(req_perm), .hw_slot(req_hw), .grant(req_grant)
    );

    // Widen the key select into a slot index for the second checker.
    always_comb key_idx = IDX_W'(key_sel);

    kss_access_ctrl #(
        .NUM_SLOTS(NUM_SLOTS), .HW_SLOTS(HW_SLOTS),
        .HW_SPLIT(HW_SPLIT),   .SW_SPLIT(SW_SPLIT)
    ) i_key_acc (
        .level(iso_level), .index(key_idx), .is_write(1'b1),
        .permitted(key_perm), .hw_slot(key_hw), .grant(key_grant)
    );

    // Write enable: granted write, suppressed by a clear.
    always_comb wr_en = req_valid && req_write && req_grant && !clr_all;

    kss_slot_array #(
        .NUM_SLOTS(NUM_SLOTS), .HW_SLOTS(HW_SLOTS),
        .SLOT_WORDS(SLOT_WORDS), .WORD_W(WORD_W)
    ) i_array (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .we(wr_en),
        .wr_idx(req_index), .wr_word(req_word), .wr_data(req_wdata),
        .rd_idx(req_index), .rd_word(req_word), .rd_data(rd_word_data),
        .hw_flat(hw_flat)
    );

    kss_key_port #(
        .HW_SLOTS(HW_SLOTS), .SLOT_WORDS(SLOT_WORDS), .WORD_W(WORD_W)
    ) i_key (
        .hw_flat(hw_flat), .key_sel(key_sel),
        .key_ok(key_perm && key_hw && key_grant), .key_out(key_out)
    );

    // Response register: strobe, error flag and read data one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (!req_grant || clr_all);
            rsp_rdata <= (req_valid && req_grant && !clr_all && !req_write)
                         ? rd_word_data : '0;
        end
    end

endmodule

// File: rtl/kss_store_chk.sv
// Property checker for kss_store, attached with a bind.
// Observes ports only. Assumes the default slot area split.
module kss_store_chk #(
    parameter int HW_SLOTS = 8,
    parameter int IDX_W    = 5,
    parameter int WORD_W   = 32,
    parameter int SLOT_W   = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        iso_level,
    input logic              clr_all,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W-1:0]  req_index,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_rdata,
    input logic [SLOT_W-1:0] key_out
);

    // R2: every accepted request is answered in the next cycle only.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: an error response never carries data.
    assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R5: a read of a hardware slot always fails.
    assert_hw_read_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (32'(req_index) < 32'(HW_SLOTS))) |=> rsp_err);

    // R3: the application level is never granted.
    assert_level3_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && iso_level == 2'd3) |=> rsp_err);

    // R6: the key bus is dark at the application level.
    assert_key_dark_l3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_level == 2'd3) |-> (key_out == '0));

    // R7: after a clear every hardware key reads as zero on the bus.
    assert_clear_wipes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (key_out == '0));

endmodule

bind kss_store kss_store_chk #(
    .HW_SLOTS(HW_SLOTS), .IDX_W(IDX_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W)
) i_kss_store_chk (
    .clk(clk), .rst_n(rst_n), .iso_level(iso_level), .clr_all(clr_all),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .key_out(key_out)
);

// File: tb/test_kss_store.sv
// Sweep bench for kss_store: every level against every slot and word,
// with a bench-side model of the storage and of the area rules.
module test_kss_store;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   iso_level;
    logic         clr_all;
    logic         req_valid;
    logic         req_write;
    logic [4:0]   req_index;
    logic [2:0]   req_word;
    logic [31:0]  req_wdata;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_rdata;
    logic [2:0]   key_sel;
    logic [255:0] key_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [32][8];

    always #4 clk = ~clk;

    kss_store i_kss_store (
        .clk(clk), .rst_n(rst_n), .iso_level(iso_level), .clr_all(clr_all),
        .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
        .req_word(req_word), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .key_sel(key_sel),
        .key_out(key_out)
    );

    // Area level of a slot, per R3.
    function automatic int area_of(input int idx);
        if (idx < 4 || (idx >= 8 && idx < 20)) return 1;
        return 2;
    endfunction

    function automatic bit may(input int lv, input int idx);
        return (lv == 0) || (lv == area_of(idx));
    endfunction

    function automatic logic [31:0] pattern(input int lv, input int idx, input int w);
        return {8'(idx), 8'(w), 8'(lv), 8'hA5} ^ 32'h3C00_0000;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request, driven at a falling edge; response sampled one cycle on.
    task automatic xact(input int lv, input bit wr, input int idx, input int w,
                        input logic [31:0] d, input bit clr,
                        output logic err, output logic [31:0] rd);
        iso_level = 2'(lv); req_valid = 1'b1; req_write = wr;
        req_index = 5'(idx); req_word = 3'(w); req_wdata = d; clr_all = clr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; clr_all = 1'b0;
        check(rsp_valid === 1'b1, "R2 rsp_valid", 256'(rsp_valid), 256'd1);
        err = rsp_err; rd = rsp_rdata;
    endtask

    task automatic read_all(input string tag);
        logic e; logic [31:0] r;
        for (int lv = 0; lv < 4; lv++)
            for (int i = 0; i < 32; i++)
                for (int w = 0; w < 8; w++) begin
                    logic xe; logic [31:0] xr;
                    xact(lv, 1'b0, i, w, 32'h0, 1'b0, e, r);
                    xe = (i < 8) || !may(lv, i);
                    xr = xe ? 32'h0 : mdl[i][w];
                    check(e === xe && r === xr, tag, {223'd0, e, r}, {223'd0, xe, xr});
                end
    endtask

    task automatic key_sweep(input string tag);
        for (int lv = 0; lv < 4; lv++)
            for (int s = 0; s < 8; s++) begin
                logic [255:0] xk;
                iso_level = 2'(lv); key_sel = 3'(s);
                #1;
                xk = '0;
                if (may(lv, s))
                    for (int w = 0; w < 8; w++) xk[w*32 +: 32] = mdl[s][w];
                check(key_out === xk, tag, key_out, xk);
            end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic e; logic [31:0] r;
        rst_n = 1'b0; iso_level = 2'd0; clr_all = 1'b0; req_valid = 1'b0;
        req_write = 1'b0; req_index = '0; req_word = '0; req_wdata = '0;
        key_sel = '0;
        for (int i = 0; i < 32; i++)
            for (int w = 0; w < 8; w++) mdl[i][w] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 reset response",
              {254'd0, rsp_valid, rsp_err}, 256'd0);
        check(key_out === '0, "R1 reset key bus", key_out, 256'd0);
        read_all("R1 reset contents");

        // R3 R4 R5: write sweep over every level and slot
        for (int lv = 0; lv < 4; lv++)
            for (int i = 0; i < 32; i++)
                for (int w = 0; w < 8; w++)
                    if (((w + lv) % 4) == (i % 4)) begin
                        logic xe;
                        xact(lv, 1'b1, i, w, pattern(lv, i, w), 1'b0, e, r);
                        xe = !may(lv, i);
                        if (!xe) mdl[i][w] = pattern(lv, i, w);
                        check(e === xe && r === 32'h0, "R3 R4 R5 write response",
                              {223'd0, e, r}, {223'd0, xe, 32'h0});
                    end

        // R2 R4 R5: read back, denied writes must have left contents alone
        read_all("R2 R4 R5 readback");
        // R6: key bus per level and select
        key_sweep("R6 key bus");

        // R7: clear with a concurrent permitted write
        xact(0, 1'b1, 10, 2, 32'hDEAD_BEEF, 1'b1, e, r);
        check(e === 1'b1 && r === 32'h0, "R7 request during clear",
              {223'd0, e, r}, {223'd0, 1'b1, 32'h0});
        for (int i = 0; i < 32; i++)
            for (int w = 0; w < 8; w++) mdl[i][w] = 32'h0;
        key_sweep("R7 key bus after clear");
        read_all("R7 contents after clear");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule